// File: doc/BRIEF.md
# Sign-Predicting ReLU Dot-Product Engine

This block evaluates ReLU(p · q) for two vectors of signed Q1.15 fixed-point numbers, such as a convolution window and its kernel weights. The pairs (p_i, q_i) stream in one per cycle and are stored in an internal buffer. When the vector is complete, the block first runs a short pass over low-precision copies of every element. Each copy keeps only the leading KEEP fraction bits of the element's magnitude. In the same pass it accumulates a worst-case bound on the error those truncations can introduce.

If the low-precision sum is at or below the negative of that bound, the full-precision sum is provably not positive. In that case the block reports a skipped evaluation, outputs zero and never starts the full-precision multiply-accumulate pass. Otherwise it accumulates the exact products over the buffered vector, applies ReLU and saturates the scaled result to 16 bits. The prediction can miss negative results, but it never calls a positive result negative.

A cycle count of the evaluation is reported with every result, so the saving from a skip is visible at the ports.

Top module: `signpred_dot`

## Requirements
- R1: During and right after reset, outValid is 0, outData is 0, outSkipped is 0 and cycleCount is 0.
- R2: While the block is idle, each cycle with inValid high stores one pair. A pair with inLast high closes the vector. The DEPTH-th pair (default 512) also closes the vector when inLast is low.
- R3: The reduced copy of an element v is sign(v)·floor(|v| / 2^(15-KEEP)), counted in units of 2^-KEEP. The magnitude is truncated toward zero and the sign is applied afterwards. KEEP defaults to 4. For example, -6143 reduces to -2 and -6144 reduces to -3.
- R4: With reduced copies a_i and b_i, the vector is predicted negative exactly when Σ a_i·b_i ≤ −Σ(|a_i| + |b_i| + 1). Equality counts as negative.
- R5: On a negative prediction, outSkipped is 1 and outData is 0. No full-precision pass runs, and cycleCount equals n+1 for an n-element vector.
- R6: A negative prediction is never made when the exact sum Σ p_i·q_i (raw integers) is greater than 0.
- R7: Without a negative prediction, outSkipped is 0 and cycleCount equals 2n+1. outData is 0 when the exact raw sum S ≤ 0, and min(floor(S / 2^15), 32767) when S > 0.
- R8: outValid is high for exactly one cycle per vector. outData, outSkipped and cycleCount keep their values until the next result.
- R9: From the cycle that closes a vector until the result is published, inValid and inLast are ignored: nothing is stored and no new vector starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An element pair is present on inAct/inWgt |
| inLast | input | 1 | Marks the final pair of the vector |
| inAct | input | DATA_W (16) | Activation element, signed Q1.15 |
| inWgt | input | DATA_W (16) | Weight element, signed Q1.15 |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | DATA_W (16) | ReLU result, saturated Q1.15, never negative |
| outSkipped | output | 1 | Result came from a negative prediction |
| cycleCount | output | $clog2(DEPTH)+2 (11) | Evaluation cycles used for the last vector |

## Verification
The assertions check on every cycle the relations that hold for any data. A skipped result is zero. Every published result is non-negative and lasts one cycle. Results hold steady between strobes. A full pass only ever follows a non-negative prediction. Loading, prediction and the full pass never overlap. The arithmetic behaviour can only be shown by the bench scenarios, which compare the published values against an independent model. These scenarios cover the exact truncation of negative elements, the equality edge of the prediction test, soundness of every skip against the exact sum, saturation, the implicit end of a full-length vector and inputs that arrive while the block is busy.

// File: rtl/signpred_pkg.sv
package signpred_pkg;

  // Strobes issued by the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic wrEn;      // store the incoming pair
    logic clrAcc;    // clear all accumulators (vector closed)
    logic predStep;  // one reduced-precision step
    logic fullStep;  // one full-precision step
    logic pubSkip;   // publish a predicted-negative result
    logic pubFull;   // publish the full-pass result
  } stb_t;

  typedef enum logic [2:0] {
    S_LOAD,
    S_PRED,
    S_DECIDE,
    S_FULL,
    S_OUT
  } ctl_state_t;

endpackage

// File: rtl/signpred_reduce.sv
// Truncates one signed operand to its leading KEEP fraction bits, toward zero.
module signpred_reduce #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 11,
  localparam int MAG_W = DATA_W - SHIFT,
  localparam int RED_W = MAG_W + 1
) (
  input  logic signed [DATA_W-1:0] opIn,
  output logic signed [RED_W-1:0]  opRed,
  output logic        [MAG_W-1:0]  opMag
);

  logic isNeg;
  logic lowZero;

  always_comb begin
    isNeg   = opIn[DATA_W-1];
    lowZero = (opIn[SHIFT-1:0] == '0);
    // Upper part of |opIn|: two's complement negation only carries into
    // the kept bits when every dropped bit is zero.
    if (isNeg) opMag = (~opIn[DATA_W-1:SHIFT]) + MAG_W'(lowZero);
    else       opMag = opIn[DATA_W-1:SHIFT];
    if (isNeg) opRed = -$signed({1'b0, opMag});
    else       opRed =  $signed({1'b0, opMag});
  end

endmodule

// File: rtl/signpred_ctrl.sv
// Sequencer: load, reduced pass, decision, optional full pass, publish.
module signpred_ctrl
  import signpred_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             predNeg,
  output stb_t             stb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic [CNT_W-1:0] cycleCount
);

  ctl_state_t       state;
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [AW-1:0]    lastIdx;
  logic [CNT_W-1:0] cnt;
  logic             closeVec;
  logic             lastRd;

  always_comb begin
    closeVec = inValid && (inLast || (wrPtr == AW'(DEPTH - 1)));
    lastRd   = (rdPtr == lastIdx);
    stb          = '0;
    stb.wrEn     = (state == S_LOAD) && inValid;
    stb.clrAcc   = (state == S_LOAD) && closeVec;
    stb.predStep = (state == S_PRED);
    stb.fullStep = (state == S_FULL);
    stb.pubSkip  = (state == S_DECIDE) && predNeg;
    stb.pubFull  = (state == S_OUT);
    wrAddr       = wrPtr;
    rdAddr       = rdPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_LOAD;
      wrPtr      <= '0;
      rdPtr      <= '0;
      lastIdx    <= '0;
      cnt        <= '0;
      cycleCount <= '0;
    end else begin
      case (state)
        S_LOAD: begin
          if (inValid) begin
            if (closeVec) begin
              lastIdx <= wrPtr;
              wrPtr   <= '0;
              rdPtr   <= '0;
              cnt     <= '0;
              state   <= S_PRED;
            end else begin
              wrPtr <= wrPtr + AW'(1);
            end
          end
        end
        S_PRED: begin
          cnt <= cnt + CNT_W'(1);
          if (lastRd) begin
            rdPtr <= '0;
            state <= S_DECIDE;
          end else begin
            rdPtr <= rdPtr + AW'(1);
          end
        end
        S_DECIDE: begin
          cnt <= cnt + CNT_W'(1);
          if (predNeg) begin
            cycleCount <= cnt + CNT_W'(1);
            state      <= S_LOAD;
          end else begin
            state <= S_FULL;
          end
        end
        S_FULL: begin
          cnt <= cnt + CNT_W'(1);
          if (lastRd) state <= S_OUT;
          else        rdPtr <= rdPtr + AW'(1);
        end
        S_OUT: begin
          cycleCount <= cnt;
          state      <= S_LOAD;
        end
        default: state <= S_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/signpred_datapath.sv
// Pair buffer, reduced product and bound accumulators, exact accumulator, output stage.
module signpred_datapath
  import signpred_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int KEEP   = 4,
  parameter int DEPTH  = 512,
  localparam int AW     = $clog2(DEPTH),
  localparam int FRAC_W = DATA_W - 1,
  localparam int SHIFT  = FRAC_W - KEEP,
  localparam int MAG_W  = DATA_W - SHIFT,
  localparam int RED_W  = MAG_W + 1,
  localparam int PROD_W = 2 * RED_W,
  localparam int ACC_W  = 2 * DATA_W + AW + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stb_t                     stb,
  input  logic [AW-1:0]            wrAddr,
  input  logic [AW-1:0]            rdAddr,
  input  logic signed [DATA_W-1:0] inAct,
  input  logic signed [DATA_W-1:0] inWgt,
  output logic                     predNeg,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outData,
  output logic                     outSkipped
);

  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((1 << (DATA_W - 1)) - 1);

  logic [2*DATA_W-1:0] pairMem [DEPTH];
  logic [2*DATA_W-1:0] rdWord;

  logic signed [DATA_W-1:0] rawOp [2];
  logic signed [RED_W-1:0]  redOp [2];
  logic        [MAG_W-1:0]  magOp [2];

  logic signed [PROD_W-1:0]   redProd;
  logic signed [2*DATA_W-1:0] fullProd;
  logic signed [ACC_W-1:0]    redAcc;
  logic signed [ACC_W-1:0]    boundAcc;
  logic signed [ACC_W-1:0]    fullAcc;
  logic signed [ACC_W-1:0]    boundTerm;
  logic signed [ACC_W-1:0]    scaled;
  logic [DATA_W-1:0]          reluSat;

  always_ff @(posedge clk) begin
    if (stb.wrEn) pairMem[wrAddr] <= {inAct, inWgt};
  end

  always_comb begin
    rdWord   = pairMem[rdAddr];
    rawOp[0] = rdWord[2*DATA_W-1:DATA_W];
    rawOp[1] = rdWord[DATA_W-1:0];
  end

  for (genvar g = 0; g < 2; g++) begin : g_reduce
    signpred_reduce #(
      .DATA_W (DATA_W),
      .SHIFT  (SHIFT)
    ) u_reduce (
      .opIn  (rawOp[g]),
      .opRed (redOp[g]),
      .opMag (magOp[g])
    );
  end

  always_comb begin
    redProd   = redOp[0] * redOp[1];
    fullProd  = rawOp[0] * rawOp[1];
    boundTerm = $signed(ACC_W'(magOp[0]) + ACC_W'(magOp[1]) + ACC_W'(1));
    predNeg   = (redAcc <= -boundAcc);
    scaled    = fullAcc >>> FRAC_W;
    if (fullAcc <= 0)          reluSat = '0;
    else if (scaled > OUT_MAX) reluSat = OUT_MAX[DATA_W-1:0];
    else                       reluSat = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAcc) begin
      redAcc   <= '0;
      boundAcc <= '0;
      fullAcc  <= '0;
    end else begin
      if (stb.predStep) begin
        redAcc   <= redAcc + {{(ACC_W-PROD_W){redProd[PROD_W-1]}}, redProd};
        boundAcc <= boundAcc + boundTerm;
      end
      if (stb.fullStep) begin
        fullAcc <= fullAcc + {{(ACC_W-2*DATA_W){fullProd[2*DATA_W-1]}}, fullProd};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outSkipped <= 1'b0;
    end else begin
      outValid <= stb.pubSkip | stb.pubFull;
      if (stb.pubSkip) begin
        outData    <= '0;
        outSkipped <= 1'b1;
      end else if (stb.pubFull) begin
        outData    <= reluSat;
        outSkipped <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/signpred_dot.sv
module signpred_dot
  import signpred_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int KEEP   = 4,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     inLast,
  input  logic signed [DATA_W-1:0] inAct,
  input  logic signed [DATA_W-1:0] inWgt,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outData,
  output logic                     outSkipped,
  output logic [CNT_W-1:0]         cycleCount
);

  stb_t          ctrlStb;
  logic          predNeg;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  signpred_ctrl #(
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inLast     (inLast),
    .predNeg    (predNeg),
    .stb        (ctrlStb),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .cycleCount (cycleCount)
  );

  signpred_datapath #(
    .DATA_W (DATA_W),
    .KEEP   (KEEP),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (ctrlStb),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .inAct      (inAct),
    .inWgt      (inWgt),
    .predNeg    (predNeg),
    .outValid   (outValid),
    .outData    (outData),
    .outSkipped (outSkipped)
  );

endmodule

// File: rtl/signpred_dot_chk.sv
module signpred_dot_chk
  import signpred_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outSkipped,
  input logic [CNT_W-1:0]  cycleCount,
  input stb_t              ctrlStb,
  input logic              predNeg
);

  // R5
  skip_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSkipped) |-> (outData == '0));

  // R5
  skip_publish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.pubSkip |=> (outValid && outSkipped));

  // R7
  full_publish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.pubFull |=> (outValid && !outSkipped));

  // R7
  nonneg_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !outData[DATA_W-1]);

  // R7
  odd_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSkipped) |-> (cycleCount[0] && cycleCount >= CNT_W'(3)));

  // R6
  no_neg_in_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.fullStep |-> !predNeg);

  // R8
  pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outData) && $stable(outSkipped) && $stable(cycleCount)));

  // R9
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlStb.wrEn | ctrlStb.clrAcc, ctrlStb.predStep, ctrlStb.fullStep,
              ctrlStb.pubSkip, ctrlStb.pubFull}));

endmodule

bind signpred_dot signpred_dot_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .outValid   (outValid),
  .outData    (outData),
  .outSkipped (outSkipped),
  .cycleCount (cycleCount),
  .ctrlStb    (ctrlStb),
  .predNeg    (predNeg)
);

// File: tb/signpred_dot_tb.sv
`timescale 1ns/1ps
module signpred_dot_tb;

  localparam int DW    = 16;
  localparam int KEEPB = 4;
  localparam int DEP   = 512;
  localparam int CW    = $clog2(DEP) + 2;
  localparam int SHFT  = DW - 1 - KEEPB;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic                 inLast = 1'b0;
  logic signed [DW-1:0] inAct = '0;
  logic signed [DW-1:0] inWgt = '0;
  logic                 outValid;
  logic [DW-1:0]        outData;
  logic                 outSkipped;
  logic [CW-1:0]        cycleCount;

  int nChecks = 0;
  int nFail   = 0;
  logic signed [DW-1:0] actV [DEP];
  logic signed [DW-1:0] wgtV [DEP];

  always #2 clk = ~clk;

  signpred_dot #(.DATA_W(DW), .KEEP(KEEPB), .DEPTH(DEP)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .inAct(inAct), .inWgt(inWgt), .outValid(outValid), .outData(outData),
    .outSkipped(outSkipped), .cycleCount(cycleCount)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint redOf(input logic signed [DW-1:0] v);
    longint m;
    m = (v < 0) ? -longint'(v) : longint'(v);
    m = m >> SHFT;
    return (v < 0) ? -m : m;
  endfunction

  task automatic model(input int n, output bit skip, output longint fullS,
                       output longint res);
    longint rs = 0;
    longint bd = 0;
    fullS = 0;
    for (int i = 0; i < n; i++) begin
      longint a = redOf(actV[i]);
      longint b = redOf(wgtV[i]);
      rs += a * b;
      bd += ((a < 0) ? -a : a) + ((b < 0) ? -b : b) + 1;
      fullS += longint'(actV[i]) * longint'(wgtV[i]);
    end
    skip = (rs <= -bd);
    if (fullS <= 0) res = 0;
    else begin
      longint q = fullS >>> (DW - 1);
      res = (q > 32767) ? 32767 : q;
    end
  endtask

  task automatic sendVec(input int n, input bit useLast);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inAct   = actV[i];
      inWgt   = wgtV[i];
      inLast  = useLast && (i == n - 1);
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  // handSkip: -1 uses the model's prediction, 0/1 is a hand-derived value.
  task automatic runCase(input string tag, input int n, input bit useLast,
                         input int handSkip, input int junk);
    bit mSkip;
    bit expSkip;
    longint fullS;
    longint expRes;
    int expCyc;
    int wait_n = 0;
    model(n, mSkip, fullS, expRes);
    expSkip = (handSkip >= 0) ? bit'(handSkip) : mSkip;
    if (expSkip) expRes = 0;
    expCyc = expSkip ? n + 1 : 2 * n + 1;
    sendVec(n, useLast);
    for (int j = 0; j < junk; j++) begin
      // R9: pairs offered while the vector is evaluated must be ignored
      inValid = 1'b1;
      inLast  = 1'b1;
      inAct   = 16'sh7fff;
      inWgt   = 16'sh7fff;
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    while (!outValid && wait_n < 4000) begin
      @(negedge clk);
      wait_n++;
    end
    if (!outValid) begin
      chk(1'b0, tag, "no result strobe", 0, 1);
      return;
    end
    chk(outSkipped == expSkip, {tag, " R4"}, "skip flag", outSkipped, expSkip);
    chk(outData == expRes[DW-1:0], {tag, " R7 R5"}, "result", outData, expRes);
    chk(cycleCount == CW'(expCyc), {tag, " R5 R7"}, "cycle count", cycleCount, expCyc);
    if (outSkipped) chk(fullS <= 0, {tag, " R6"}, "skip with positive exact sum", fullS, 0);
    @(negedge clk);
    chk(!outValid, {tag, " R8"}, "strobe width", outValid, 0);
    chk(outData == expRes[DW-1:0], {tag, " R8"}, "result hold", outData, expRes);
  endtask

  task automatic testReset();
    chk(outValid == 1'b0, "R1", "outValid", outValid, 0);
    chk(outData == '0, "R1", "outData", outData, 0);
    chk(outSkipped == 1'b0, "R1", "outSkipped", outSkipped, 0);
    chk(cycleCount == '0, "R1", "cycleCount", cycleCount, 0);
  endtask

  task automatic testTruncation();
    // R3: 6720 -> 3, -4096 -> -2: -6 <= -6 predicted negative (R4 equality)
    actV[0] = 16'sd6720;  wgtV[0] = -16'sd4096; runCase("R4 equality", 1, 1'b1, 1, 0);
    // R3: 6143 -> 2, -6143 -> -2: -4 > -5, full pass, result 0
    actV[0] = 16'sd6143;  wgtV[0] = -16'sd6143; runCase("R3 pos cut", 1, 1'b1, 0, 0);
    // R3: -6143 -> -2 (toward zero), 4096 -> 2: -4 > -5, full pass
    actV[0] = -16'sd6143; wgtV[0] = 16'sd4096;  runCase("R3 neg cut", 1, 1'b1, 0, 0);
    // R3: -6144 -> -3, 4096 -> 2: -6 <= -6, skipped
    actV[0] = -16'sd6144; wgtV[0] = 16'sd4096;  runCase("R3 neg exact", 1, 1'b1, 1, 0);
  endtask

  task automatic testStrongCases();
    for (int i = 0; i < 10; i++) begin
      actV[i] = 16'sd16000; wgtV[i] = -16'sd16000;
    end
    runCase("R5 strong negative", 10, 1'b1, 1, 0);
    for (int i = 0; i < 6; i++) begin
      actV[i] = 16'sd3000 + 16'(i * 100); wgtV[i] = 16'sd5000;
    end
    runCase("R7 positive", 6, 1'b1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      actV[i] = 16'sh7fff; wgtV[i] = 16'sh7fff;
    end
    runCase("R7 saturate", 4, 1'b1, 0, 0);
    actV[0] = -16'sd32768; wgtV[0] = -16'sd32768;
    runCase("R7 min squared", 1, 1'b1, 0, 0);
  endtask

  task automatic testFullLength();
    for (int i = 0; i < DEP; i++) begin
      actV[i] = 16'sd100; wgtV[i] = 16'sd200;
    end
    runCase("R2 implicit end", DEP, 1'b0, 0, 0);
  endtask

  task automatic testBusyIgnore();
    for (int i = 0; i < 8; i++) begin
      actV[i] = 16'sd1000 * 16'(i + 1); wgtV[i] = 16'sd2500;
    end
    runCase("R9 busy", 8, 1'b1, 0, 5);
    actV[0] = 16'sd12000; wgtV[0] = 16'sd9000;
    actV[1] = -16'sd500;  wgtV[1] = 16'sd700;
    runCase("R9 after busy", 2, 1'b1, 0, 0);
  endtask

  task automatic testRandom();
    for (int v = 0; v < 24; v++) begin
      int n = $urandom_range(1, 40);
      for (int i = 0; i < n; i++) begin
        int w = int'($urandom_range(0, 8000)) + int'($urandom_range(0, 8000)) +
                int'($urandom_range(0, 8000)) + int'($urandom_range(0, 8000)) - 16000;
        int a = (v % 2 == 0) ? int'($urandom_range(0, 65535)) - 32768
                             : int'($urandom_range(0, 32767));
        actV[i] = 16'(a);
        wgtV[i] = 16'(w);
      end
      runCase("R6 random", n, 1'b1, -1, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTruncation();
    testStrongCases();
    testFullLength();
    testBusyIgnore();
    testRandom();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule